// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide, 256-word first-in first-out buffer. Its write side and read side run on separate clocks. The two clocks may be unrelated, or they may be the same net. A producer stores a word on each rising write-clock edge while its active-low write strobe is low. A consumer moves the oldest word into a holding output register on each rising read-clock edge while its active-low read strobe is low. An active-low output qualifier forces the data bus to zero when high, in place of a tri-state pad.

Five active-low status flags are provided:
- full, half-full and almost-full are computed in the write domain;
- empty and almost-empty are computed in the read domain.

The almost-empty threshold and the almost-full threshold are inputs driven by a neighbouring configuration block, so they can change at run time. Each side sees the other side's position as a Gray-coded pointer passed through a two-stage synchroniser. Flags that depend on the far side can therefore lag by a few cycles, but always in the safe direction.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low and after it is released, the FIFO holds no words. `full_n`, `half_n` and `afull_n` read 1, `empty_n` and `aempty_n` read 0, and `rdata` (with `oe_n` low) reads 18'h0.
- R2: Words written with `wen_n` low are returned on `rdata` in the same order, one per read-clock edge with `ren_n` low, whatever the ratio of the two clock periods. This holds across pointer wrap-around.
- R3: While `wen_n` is high, no word is stored, whatever `wdata` carries.
- R4: `full_n` goes low once 256 words are held. While it is low, a write strobe is ignored and the stored contents stay unchanged.
- R5: `empty_n` is low whenever no word is held. While it is low, a read strobe is ignored and `rdata` keeps its last word.
- R6: While `ren_n` is high, `rdata` keeps the word it last showed.
- R7: `half_n` is low exactly when more than 128 words are held, once the pointers have settled.
- R8: `afull_n` is low exactly when the free space (256 minus words held) is less than or equal to `af_ofs`, once settled.
- R9: `aempty_n` is low exactly when the words held are less than or equal to `ae_ofs`, once settled.
- R10: While `oe_n` is high, `rdata` reads 18'h0. When `oe_n` returns low, the held word shows again.
- R11: With the read clock tied to the write clock, ordering and flags behave as in R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock, unrelated to or equal to `wclk` |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen_n | input | 1 | Active-low write strobe |
| wdata | input | 18 | Word to store |
| ren_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output qualifier; high forces `rdata` to zero |
| ae_ofs | input | 8 | Almost-empty threshold in words |
| af_ofs | input | 8 | Almost-full threshold in free words |
| rdata | output | 18 | Output register contents, qualified by `oe_n` |
| full_n | output | 1 | Low when 256 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_n | output | 1 | Low when more than 128 words are held |
| afull_n | output | 1 | Low when free space is at or below `af_ofs` |
| aempty_n | output | 1 | Low when words held are at or below `ae_ofs` |

## Verification
The bench steps the fill level onto each side of every threshold: `ae_ofs` and one above it, 128 and 129, 256 minus `af_ofs` and one below it. A comparison that is off by one or uses a strict inequality would flip a flag one word early or late. It overfills by one word and over-drains by one word. A design that counted an ignored strobe would return a stray word, or would report not-empty after exactly 256 reads. Long concurrent streams under unrelated and identical clocks wrap the pointers. A wrong Gray conversion or a missing wrap bit would scramble the order, or would read a full buffer as empty.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DFLT_DATA_W = 18;
  localparam int DFLT_ADDR_W = 8;
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_gray,
  output logic [W-1:0] q_gray
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_gray <= '0;
    end else begin
      stage1 <= d_gray;
      q_gray <= stage1;
    end
  end
endmodule

// File: rtl/dcf_store.sv
module dcf_store #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wen_n,
  input  logic [AW-1:0] af_ofs,
  input  logic [AW:0]   rgray_sync,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic          full_n,
  output logic          half_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << AW);
  localparam logic [PW-1:0] HALF_V  = PW'(1 << (AW - 1));

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nxt, rbin_seen, used, spare;
  logic          is_full;

  assign rbin_seen = from_gray(rgray_sync);
  assign used      = wbin - rbin_seen;
  assign spare     = DEPTH_V - used;
  assign is_full   = (used == DEPTH_V);
  assign wr_fire   = !wen_n && !is_full;
  assign wbin_nxt  = wbin + PW'(wr_fire);
  assign waddr     = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= to_gray(wbin_nxt);
    end
  end

  assign full_n  = !is_full;
  assign half_n  = !(used > HALF_V);
  assign afull_n = !(spare <= {1'b0, af_ofs});

  // R4
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n && !wen_n) |=> $stable(wbin));
  // R4
  fill_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    used <= DEPTH_V);
  // R2
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R7
  half_before_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> (!half_n && !afull_n));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ren_n,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW:0]   wgray_sync,
  input  logic [DW-1:0] rword,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] rbin, rbin_nxt, wbin_seen, avail;
  logic          is_empty, rd_fire;

  assign wbin_seen = from_gray(wgray_sync);
  assign avail     = wbin_seen - rbin;
  assign is_empty  = (avail == '0);
  assign rd_fire   = !ren_n && !is_empty;
  assign rbin_nxt  = rbin + PW'(rd_fire);
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      dout  <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= to_gray(rbin_nxt);
      if (rd_fire) dout <= rword;
    end
  end

  assign empty_n  = !is_empty;
  assign aempty_n = !(avail <= {1'b0, ae_ofs});

  // R5
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !ren_n) |=> ($stable(rbin) && $stable(dout)));
  // R6
  hold_idle_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    ren_n |=> $stable(dout));
  // R9
  aempty_with_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcf_pkg::*;
#(
  parameter int DATA_W = DFLT_DATA_W,
  parameter int ADDR_W = DFLT_ADDR_W
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ren_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] ae_ofs,
  input  logic [ADDR_W-1:0] af_ofs,
  output logic [DATA_W-1:0] rdata,
  output logic              full_n,
  output logic              empty_n,
  output logic              half_n,
  output logic              afull_n,
  output logic              aempty_n
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wgray, wgray_r, rgray, rgray_w;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire;
  logic [DATA_W-1:0] rword, dout;

  dcf_wr_ctrl #(.AW(ADDR_W)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .af_ofs(af_ofs),
    .rgray_sync(rgray_w), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
    .full_n(full_n), .half_n(half_n), .afull_n(afull_n)
  );

  dcf_gray_sync #(.W(PW)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d_gray(wgray), .q_gray(wgray_r)
  );

  dcf_gray_sync #(.W(PW)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d_gray(rgray), .q_gray(rgray_w)
  );

  dcf_store #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wword(wdata),
    .raddr(raddr), .rword(rword)
  );

  dcf_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .ae_ofs(ae_ofs),
    .wgray_sync(wgray_r), .rword(rword), .rgray(rgray), .raddr(raddr),
    .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign rdata = oe_n ? '0 : dout;

  // R10
  oe_blank_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    oe_n |-> (rdata == '0));
endmodule

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;
  localparam int DEPTH = 256;
  localparam int AE = 10;
  localparam int AF = 20;

  logic wclk = 1'b0, rclk_free = 1'b0, same_clk = 1'b0;
  logic rclk;
  logic rst_n = 1'b0, wen_n = 1'b1, ren_n = 1'b1, oe_n = 1'b0;
  logic [17:0] wdata = '0;
  logic [7:0] ae_ofs = 8'(AE), af_ofs = 8'(AF);
  logic [17:0] rdata;
  logic full_n, empty_n, half_n, afull_n, aempty_n;

  always #4 wclk = ~wclk;
  always #5.5 rclk_free = ~rclk_free;
  assign rclk = same_clk ? wclk : rclk_free;

  dcfifo_pflag u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .wdata(wdata),
    .ren_n(ren_n), .oe_n(oe_n), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rdata(rdata), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
    .afull_n(afull_n), .aempty_n(aempty_n)
  );

  int vectors = 0, fails = 0;
  logic [17:0] model[$];
  logic [17:0] last_word = '0;
  int seed = 1;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] next_word();
    logic [17:0] v = 18'(seed * 37) ^ 18'h15A5A;
    seed++;
    return v;
  endfunction

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; oe_n = 1'b0;
    repeat (4) @(negedge wclk);
    rst_n = 1'b1;
    model.delete();
    last_word = '0;
    repeat (3) @(negedge wclk);
  endtask

  task automatic check_flags(string req);
    int n = model.size();
    chk(req, "full_n",   full_n,   (n == DEPTH) ? 0 : 1);
    chk(req, "empty_n",  empty_n,  (n == 0) ? 0 : 1);
    chk(req, "half_n",   half_n,   (n > DEPTH / 2) ? 0 : 1);
    chk(req, "afull_n",  afull_n,  ((DEPTH - n) <= AF) ? 0 : 1);
    chk(req, "aempty_n", aempty_n, (n <= AE) ? 0 : 1);
  endtask

  task automatic push_words(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen_n = 1'b0;
      wdata = next_word();
      if (model.size() < DEPTH) model.push_back(wdata);
    end
    @(negedge wclk);
    wen_n = 1'b1;
  endtask

  task automatic pop_words(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); ren_n = 1'b0;
      @(negedge rclk); ren_n = 1'b1;
      if (model.size() > 0) begin
        last_word = model.pop_front();
        chk(req, "read word", rdata, last_word);
      end else begin
        chk("R5", "hold on empty read", rdata, last_word);
      end
    end
  endtask

  task automatic stream(int n, string req);
    fork
      begin
        int sent = 0;
        while (sent < n) begin
          @(negedge wclk);
          if (full_n) begin
            wen_n = 1'b0; wdata = next_word(); model.push_back(wdata); sent++;
          end else wen_n = 1'b1;
        end
        @(negedge wclk); wen_n = 1'b1;
      end
      begin
        int got = 0;
        logic pend = 1'b0;
        while (got < n) begin
          @(negedge rclk);
          if (pend) begin
            last_word = model.pop_front();
            chk(req, "stream word", rdata, last_word);
            got++;
          end
          pend = 1'b0; ren_n = 1'b1;
          if (empty_n && got < n) begin ren_n = 1'b0; pend = 1'b1; end
        end
        ren_n = 1'b1;
      end
    join
    settle();
    check_flags(req);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "rdata after reset", rdata, 0);
    check_flags("R1");
  endtask

  task automatic t_order();
    push_words(5); settle(); check_flags("R2");
    pop_words(5, "R2"); settle(); check_flags("R2");
  endtask

  task automatic t_wen_idle();
    for (int i = 0; i < 10; i++) begin
      @(negedge wclk); wen_n = 1'b1; wdata = 18'(i * 977 + 3);
    end
    settle();
    chk("R3", "empty_n after idle strobes", empty_n, 0);
    push_words(1); settle();
    pop_words(1, "R3");
    settle();
    chk("R3", "empty_n after single pop", empty_n, 0);
  endtask

  task automatic t_full();
    push_words(DEPTH + 1); settle();
    chk("R4", "full_n at 256", full_n, 0);
    check_flags("R4");
    pop_words(DEPTH, "R4"); settle();
    chk("R4", "empty after 256 reads", empty_n, 0);
    check_flags("R5");
    pop_words(1, "R5"); settle();
    chk("R5", "still empty", empty_n, 0);
  endtask

  task automatic t_hold_oe();
    push_words(2); settle();
    pop_words(1, "R6");
    for (int i = 0; i < 5; i++) begin
      @(negedge rclk);
      chk("R6", "hold with ren_n high", rdata, last_word);
    end
    oe_n = 1'b1;
    @(negedge rclk);
    chk("R10", "rdata blanked", rdata, 0);
    oe_n = 1'b0;
    @(negedge rclk);
    chk("R10", "rdata restored", rdata, last_word);
    pop_words(1, "R6"); settle();
  endtask

  task automatic t_thresholds(string tag);
    push_words(AE); settle(); check_flags("R9");
    push_words(1); settle(); check_flags("R9");
    push_words(DEPTH / 2 - model.size()); settle(); check_flags("R7");
    push_words(1); settle(); check_flags("R7");
    push_words(DEPTH - AF - 1 - model.size()); settle(); check_flags("R8");
    push_words(1); settle(); check_flags("R8");
    pop_words(model.size(), tag); settle(); check_flags(tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_wen_idle();
    t_full();
    t_hold_oe();
    t_thresholds("R2");
    stream(300, "R2");
    same_clk = 1'b1;
    t_reset();
    stream(300, "R11");
    t_thresholds("R11");
    push_words(DEPTH + 1); settle(); check_flags("R11");
    pop_words(DEPTH, "R11"); settle(); check_flags("R11");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule